// File: doc/BRIEF.md
# Program-Memory Table Read Unit

This block lets an instruction stream pull 16-bit constants out of program memory into 8-bit data registers. It holds a 16-bit table pointer and a 16-bit table latch. The decoder hands it one operation at a time over a valid/ready handshake. A latch-only read returns one byte of the latch. A full read returns one latch byte and then refills the whole latch from program memory at the pointer. It can also step the pointer forward by one.

A full read hands out the latch byte before the refill, so the first full read after the pointer is set gives back a stale byte, which software treats as a dummy. The refill takes over the next instruction cycle. That cycle becomes a data read cycle on the multiplexed address/data bus, and the block raises `stall` for it so the fetch unit holds the program counter. Each instruction cycle is four clocks long, phases Q1 to Q4. ALE strobes the address in Q1, the address is driven in Q1 and Q2, and OE is active (low) in Q3 and Q4.

The operation interface has valid/ready back-pressure. `op_ready` is high only in Q1 of an instruction cycle with no data read pending. An offered operation is held with `op_valid` until it is taken. The result side carries no back-pressure: the register file always takes `res_data` in the clock that `res_valid` is high.

Top module: `tblrd_unit`

## Requirements
- R1: While reset is asserted and right after it, the pointer and latch are zero, ALE is low, OE_n is high, WR_n is high, and `stall`, `res_valid` and `op_ready` are low.
- R2: An operation is taken only on a clock where `op_valid` and `op_ready` are both high. `op_ready` is high only in Q1, the clock in which ALE is high, and only while no data read is pending.
- R3: `res_valid` pulses for one clock after an operation is taken. `res_data` is latch[15:8] when `op_hi`=1 and latch[7:0] when `op_hi`=0, taken from the latch as it was before any refill. The first full read after reset therefore returns 0x00.
- R4: A latch-only read (`op_full`=0) starts no data read cycle and never raises `stall`. It leaves the latch and the pointer unchanged.
- R5: A full read (`op_full`=1) turns the next instruction cycle into a data read cycle. `stall` is high for exactly its four clocks, and in its Q1 ALE is high and `ad_out` equals the pointer.
- R6: At the end of Q4 of the data read cycle, the latch loads the word on `ad_in`.
- R7: A full read with `op_inc`=1 adds one to the pointer after the access, and 0xFFFF wraps to 0x0000. With `op_inc`=0 the pointer is unchanged.
- R8: `ptr_wr_hi` loads `ptr_wdata` into pointer bits 15:8 and `ptr_wr_lo` loads it into bits 7:0. Both writes are ignored while `stall` is high.
- R9: In every instruction cycle, ALE is high in Q1 only, `ad_en` is high in Q1 and Q2 only, OE_n is low in Q3 and Q4 only, and WR_n stays high.
- R10: Outside a data read cycle, `ad_out` carries `pc_in`.
- R11: Back-to-back full reads each get their own data read cycle with their own pointer value. The second is not taken until the first one's data read cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | An operation can be taken this clock |
| op_full | input | 1 | 1 = full read, 0 = latch-only read |
| op_hi | input | 1 | 1 = high latch byte, 0 = low latch byte |
| op_inc | input | 1 | 1 = increment the pointer after a full read |
| res_valid | output | 1 | Result byte is valid for one clock |
| res_data | output | 8 | Result byte |
| ptr_wr_hi | input | 1 | Write the high pointer byte |
| ptr_wr_lo | input | 1 | Write the low pointer byte |
| ptr_wdata | input | 8 | Pointer write data |
| pc_in | input | 16 | Fetch address driven in normal cycles |
| stall | output | 1 | Data read cycle in progress; hold the PC |
| ad_out | output | 16 | Address driven onto the bus |
| ad_en | output | 1 | Address drive enable (address phase) |
| ad_in | input | 16 | Word read from the bus |
| ale | output | 1 | Address latch enable |
| oe_n | output | 1 | Output enable, active low |
| wr_n | output | 1 | Write strobe, active low (always high) |

## Verification
The embedded properties assume that the decoder never makes pointer writes while `stall` is high, except where that case is being tested on purpose. They also assume all inputs are known after reset. The stimulus offers operations only from the handshake task, holding `op_valid` until the handshake completes. Pointer writes are made between operations, apart from one directed write placed inside a data read cycle. The memory model drives `ad_in` from the address captured at ALE, so the word stays steady through Q3 and Q4.

// File: rtl/tblrd_pkg.sv
`timescale 1ns/1ps
package tblrd_pkg;
  typedef enum logic [1:0] {
    TR_IDLE  = 2'd0,
    TR_PEND  = 2'd1,
    TR_DREAD = 2'd2
  } tr_state_e;

  localparam int NUM_PHASES = 4;
  localparam int PHASE_W    = $clog2(NUM_PHASES);
endpackage

// File: rtl/tblrd_phase.sv
`timescale 1ns/1ps
module tblrd_phase
  import tblrd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  output logic [PHASE_W-1:0] q,
  output logic               q1,
  output logic               q4,
  output logic               ale,
  output logic               oe_n,
  output logic               ad_en
);
  localparam logic [PHASE_W-1:0] PH_Q1 = PHASE_W'(0);
  localparam logic [PHASE_W-1:0] PH_Q2 = PHASE_W'(1);
  localparam logic [PHASE_W-1:0] PH_Q3 = PHASE_W'(2);
  localparam logic [PHASE_W-1:0] PH_Q4 = PHASE_W'(NUM_PHASES - 1);

  logic [PHASE_W-1:0] q_nxt;
  assign q_nxt = q + 1'b1;
  assign q1    = (q == PH_Q1);
  assign q4    = (q == PH_Q4);

  // Strobes are registered for the phase being entered.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= PH_Q4;
      ale   <= 1'b0;
      oe_n  <= 1'b1;
      ad_en <= 1'b0;
    end else begin
      q     <= q_nxt;
      ale   <= (q_nxt == PH_Q1);
      ad_en <= (q_nxt == PH_Q1) || (q_nxt == PH_Q2);
      oe_n  <= !((q_nxt == PH_Q3) || (q_nxt == PH_Q4));
    end
  end

  // R9
  bus_no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ad_en);
  // R9
  ale_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  // R9
  oe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> $past(ale, 2));
endmodule

// File: rtl/tblrd_ptr.sv
`timescale 1ns/1ps
module tblrd_ptr #(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [AW/2-1:0] wdata,
  input  logic            wr_block,
  input  logic            inc,
  output logic [AW-1:0]   ptr
);
  localparam int HW = AW / 2;

  logic [AW-1:0] ptr_plus;
  logic [1:0]    wr_sel;

  assign ptr_plus = ptr + 1'b1;
  assign wr_sel   = {wr_hi, wr_lo} & ~{2{wr_block}};

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HW-1:0] half_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         half_q <= '0;
      else if (wr_sel[h]) half_q <= wdata;
      else if (inc)       half_q <= ptr_plus[h*HW +: HW];
    end
    assign ptr[h*HW +: HW] = half_q;
  end

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_hi && !wr_lo && (&ptr)) |=> (ptr == '0));
  // R8
  ptr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block && !inc) |=> $stable(ptr));
endmodule

// File: rtl/tblrd_latch.sv
`timescale 1ns/1ps
module tblrd_latch #(
  parameter int WW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WW-1:0]   din,
  input  logic            sel_hi,
  output logic [WW/2-1:0] byte_out
);
  localparam int BW = WW / 2;

  logic [WW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= din;
  end

  assign byte_out = sel_hi ? word_q[WW-1:BW] : word_q[BW-1:0];
endmodule

// File: rtl/tblrd_unit.sv
`timescale 1ns/1ps
module tblrd_unit
  import tblrd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic                op_full,
  input  logic                op_hi,
  input  logic                op_inc,
  output logic                res_valid,
  output logic [WORD_W/2-1:0] res_data,
  input  logic                ptr_wr_hi,
  input  logic                ptr_wr_lo,
  input  logic [ADDR_W/2-1:0] ptr_wdata,
  input  logic [ADDR_W-1:0]   pc_in,
  output logic                stall,
  output logic [ADDR_W-1:0]   ad_out,
  output logic                ad_en,
  input  logic [WORD_W-1:0]   ad_in,
  output logic                ale,
  output logic                oe_n,
  output logic                wr_n
);
  localparam int BYTE_W = WORD_W / 2;

  tr_state_e          state;
  logic               inc_pend;
  logic [PHASE_W-1:0] q;
  logic               q1, q4;
  logic               fire;
  logic               refill;
  logic [ADDR_W-1:0]  ptr;
  logic [BYTE_W-1:0]  sel_byte;

  tblrd_phase u_phase (
    .clk(clk), .rst_n(rst_n), .q(q), .q1(q1), .q4(q4),
    .ale(ale), .oe_n(oe_n), .ad_en(ad_en)
  );

  assign op_ready = q1 && (state == TR_IDLE);
  assign fire     = op_valid && op_ready;
  assign stall    = (state == TR_DREAD);
  assign refill   = stall && q4;
  assign ad_out   = stall ? ptr : pc_in;
  assign wr_n     = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= TR_IDLE;
      inc_pend <= 1'b0;
    end else begin
      unique case (state)
        TR_IDLE:  if (fire && op_full) begin
                    state    <= TR_PEND;
                    inc_pend <= op_inc;
                  end
        TR_PEND:  if (q4) state <= TR_DREAD;
        TR_DREAD: if (q4) state <= TR_IDLE;
        default:  state <= TR_IDLE;
      endcase
    end
  end

  tblrd_ptr #(.AW(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_hi(ptr_wr_hi), .wr_lo(ptr_wr_lo),
    .wdata(ptr_wdata), .wr_block(stall), .inc(refill && inc_pend), .ptr(ptr)
  );

  tblrd_latch #(.WW(WORD_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(refill), .din(ad_in),
    .sel_hi(op_hi), .byte_out(sel_byte)
  );

  // Byte is captured at acceptance, before the refill that follows.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= fire;
      if (fire) res_data <= sel_byte;
    end
  end

  // R2
  ready_only_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (ale && !stall));
  // R3
  result_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> res_valid);
  // R4
  latch_only_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_full) |-> ##4 !stall);
  // R5
  full_read_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_full) |-> ##4 stall);
  // R5
  stall_four_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> ($past(stall, 4) && !$past(stall, 5)));
  // R5
  stall_starts_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> ale);
  // R11
  no_result_in_dread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !stall);
endmodule

// File: tb/tblrd_unit_test.sv
`timescale 1ns/1ps
module tblrd_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_full = 1'b0, op_hi = 1'b0, op_inc = 1'b0;
  logic        op_ready, res_valid, stall, ad_en, ale, oe_n, wr_n;
  logic [7:0]  res_data;
  logic        ptr_wr_hi = 1'b0, ptr_wr_lo = 1'b0;
  logic [7:0]  ptr_wdata = '0;
  logic [15:0] pc_in = 16'h0400;
  logic [15:0] ad_out, ad_in, cap_addr = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] ptr_m = '0, latch_m = '0;

  always #10 clk = ~clk;

  tblrd_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_full(op_full), .op_hi(op_hi), .op_inc(op_inc),
    .res_valid(res_valid), .res_data(res_data),
    .ptr_wr_hi(ptr_wr_hi), .ptr_wr_lo(ptr_wr_lo), .ptr_wdata(ptr_wdata),
    .pc_in(pc_in), .stall(stall), .ad_out(ad_out), .ad_en(ad_en),
    .ad_in(ad_in), .ale(ale), .oe_n(oe_n), .wr_n(wr_n)
  );

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + 8'h3C};
  endfunction

  function automatic logic [7:0] pick(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  // Program memory model: address captured while ALE is high.
  always @(negedge clk) if (ale) cap_addr <= ad_out;
  assign ad_in = mem_word(cap_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic ptr_write(input logic hi, input logic [7:0] v);
    @(negedge clk);
    ptr_wr_hi = hi; ptr_wr_lo = !hi; ptr_wdata = v;
    @(negedge clk);
    ptr_wr_hi = 0; ptr_wr_lo = 0;
    if (hi) ptr_m[15:8] = v; else ptr_m[7:0] = v;
  endtask

  task automatic do_op(input logic full, input logic hi, input logic inc,
                       input bit inject_wr);
    logic [7:0] exp_b;
    @(negedge clk);
    op_valid = 1; op_full = full; op_hi = hi; op_inc = inc;
    while (!op_ready) begin
      @(negedge clk);
      chk("R2 no result before handshake", res_valid, 0);
    end
    exp_b = pick(latch_m, hi);
    @(negedge clk);
    op_valid = 0;
    chk("R3 res_valid", res_valid, 1);
    chk("R3 res_data", res_data, exp_b);
    if (full) begin
      @(negedge clk); chk("R5 no stall in issue cycle", stall, 0);
      @(negedge clk); chk("R5 no stall in issue cycle", stall, 0);
      @(negedge clk);
      chk("R5 stall in Q1", stall, 1);
      chk("R5 ALE in data read Q1", ale, 1);
      chk("R11 data read address", ad_out, ptr_m);
      chk("R9 address driven Q1", ad_en, 1);
      chk("R9 WR high", wr_n, 1);
      chk("R2 not ready in data read", op_ready, 0);
      @(negedge clk);
      chk("R9 ALE low Q2", ale, 0);
      chk("R5 stall Q2", stall, 1);
      if (inject_wr) begin ptr_wr_lo = 1; ptr_wdata = ~ptr_m[7:0]; end
      @(negedge clk);
      ptr_wr_lo = 0;
      chk("R9 OE low Q3", oe_n, 0);
      chk("R9 address released Q3", ad_en, 0);
      @(negedge clk);
      chk("R9 OE low Q4", oe_n, 0);
      chk("R5 stall Q4", stall, 1);
      latch_m = mem_word(ptr_m);
      if (inc) ptr_m = ptr_m + 16'd1;
    end else begin
      for (int k = 0; k < 7; k++) begin
        @(negedge clk);
        chk("R4 latch-only never stalls", stall, 0);
        if (ale) chk("R10 fetch address", ad_out, pc_in);
      end
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 ALE idle", ale, 0);
    chk("R1 OE idle", oe_n, 1);
    chk("R1 WR idle", wr_n, 1);
    chk("R1 stall idle", stall, 0);
    chk("R1 no result", res_valid, 0);
    chk("R1 not ready", op_ready, 0);
    rst_n = 1;

    // R3 dummy first read returns the cleared latch; R6 refill from address 0
    do_op(1, 1, 0, 0);
    do_op(1, 0, 0, 0);
    // R8 pointer writes, R7 increment
    ptr_write(1, 8'h12);
    ptr_write(0, 8'h34);
    do_op(1, 0, 1, 0);
    do_op(1, 1, 0, 0);
    // R4 latch-only twice gives the same byte
    do_op(0, 1, 0, 0);
    do_op(0, 1, 0, 0);
    // R7 wrap 0xFFFF -> 0x0000
    ptr_write(1, 8'hFF);
    ptr_write(0, 8'hFF);
    do_op(1, 0, 1, 0);
    do_op(1, 0, 0, 0);
    // R8 write inside a data read cycle is ignored
    ptr_write(0, 8'h77);
    do_op(1, 1, 0, 1);
    do_op(1, 1, 1, 0);

    for (int i = 0; i < 80; i++) begin
      int r = $urandom % 8;
      pc_in = 16'($urandom);
      case (r)
        0: ptr_write(1, 8'($urandom));
        1: ptr_write(0, 8'($urandom));
        2: do_op(0, 1'($urandom), 1'($urandom), 0);
        default: do_op(1, 1'($urandom), 1'($urandom), (r == 7));
      endcase
    end
    // R11 back-to-back full reads
    do_op(1, 0, 1, 0);
    do_op(1, 1, 1, 0);
    do_op(1, 0, 0, 0);
    finish_run();
  end
endmodule